// File: doc/BRIEF.md
# Out-of-Band Upstream Message Transmitter

This block sits on the peripheral side of a host link. It sends one out-of-band message from local firmware toward the host. Firmware fills a staging buffer and three header bytes through a byte-wide register bus. The header bytes are the message kind, a combined tag/length-high byte and a length-low byte. Firmware then sets the enable bit, and in a later write sets the go bit. The engine checks the 12-bit payload length against the buffer size. It then streams the header followed by the payload as an ordered byte sequence on a valid/ready port toward the link layer. The final byte carries a last flag.

Completion is reported through a write-one-to-clear done bit, and firmware retires the transfer by dropping enable. A length that exceeds the buffer is refused. In that case the engine raises an error flag and done, and nothing is sent. If the host switches off the channel while a message is pending, the engine abandons the message and latches a channel-disabled flag. Done and channel-disabled both feed a level interrupt that is gated by an interrupt-enable bit.

Top module: `oob_upstream_tx`

## Requirements
- R1: After reset, every register (control, message kind, tag/length-high, length-low) reads 0, the staging buffer reads 0, tx_valid is 0 and irq is 0.
- R2: The byte bus decodes these addresses. Payload bytes sit at 0x00..0x4F and read back as written. Control is at 0x80 with bit 7 enable, bit 6 go, bit 5 interrupt enable, bit 3 length error, bit 2 channel disabled, bit 1 done and bit 0 busy. Message kind is at 0x81. Tag/length-high is at 0x82, with tag in bits 7:4 and length bits 11:8 in bits 3:0. Length-low is at 0x83. Go always reads back as 0.
- R3: A transfer starts only when a control write sets go while enable already held 1 before that write and busy is 0. Go written with enable previously 0 sends nothing.
- R4: A transfer emits the message-kind byte, the tag/length-high byte, the length-low byte, then payload bytes 0 to N-1. tx_last is 1 on the final byte only.
- R5: While tx_valid is 1 and tx_ready is 0, tx_data and tx_last hold their values.
- R6: Busy reads 1 from the cycle after an accepted go until the final byte is taken. Done is set in the cycle after that final handshake, and busy clears at the same time.
- R7: A 12-bit length above 80 (including any nonzero length-high nibble) emits no byte. It sets the length-error bit and done instead.
- R8: Done, length error and channel disabled are cleared by writing 1 to their bit. Writing 0 to them leaves them unchanged.
- R9: If host_chan_off is 1 while busy, the message is abandoned. tx_valid drops in the next cycle, channel disabled is set and done is not set.
- R10: irq is 1 exactly when interrupt enable is 1 and either done or channel disabled is 1. It stays high until software clears the cause.
- R11: While busy, a second go is ignored and writes to the header registers and the staging buffer are discarded, so the message in flight is unchanged.
- R12: A length of 0 emits only the three header bytes, with tx_last on the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register bus write strobe |
| bus_addr | input | 8 | Register bus byte address |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data, combinational from bus_addr |
| host_chan_off | input | 1 | Host has disabled the out-of-band channel |
| tx_valid | output | 1 | A message byte is offered to the link layer |
| tx_ready | input | 1 | The link layer takes the offered byte |
| tx_data | output | 8 | Offered message byte |
| tx_last | output | 1 | Offered byte is the final byte of the message |
| irq | output | 1 | Level interrupt toward firmware |

## Verification
Several properties are checked by assertions on every cycle. The offered byte holds while the link stalls. The byte index never runs past the final byte. Done follows the last handshake and busy drops with it. A refused length never raises tx_valid. A channel-off abort clears busy. Header registers stay frozen while busy. Done obeys write-one-to-clear in both directions. The interrupt stays high until its cause is cleared. Only the bench's scenarios can show the rest:
- the exact byte order and content for several lengths and tag values under varied ready patterns;
- the enable-before-go rule;
- the refusal of an oversized high nibble;
- that writes made during a transfer never reach the stream.

// File: rtl/oobtx_pkg.sv
package oobtx_pkg;

   // control register bit positions (software visible)
   localparam int CTL_EN    = 7;
   localparam int CTL_GO    = 6;
   localparam int CTL_IE    = 5;
   localparam int CTL_ERR   = 3;
   localparam int CTL_CHDIS = 2;
   localparam int CTL_DONE  = 1;
   localparam int CTL_BUSY  = 0;

   // bytes of header preceding the payload on the stream
   localparam int HDR_BYTES = 3;
   localparam int LEN_W     = 12;

   typedef struct packed {
      logic [7:0] kind;
      logic [7:0] taglen;
      logic [7:0] lenlo;
   } oob_hdr_t;

   typedef struct packed {
      logic en;
      logic ie;
      logic err;
      logic chdis;
      logic done;
   } oob_ctl_t;

endpackage

// File: rtl/oobtx_regs.sv
module oobtx_regs
   import oobtx_pkg::*;
#(
   parameter int                ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   input  logic              busy,
   input  logic              set_done,
   input  logic              set_err,
   input  logic              set_chdis,
   output oob_hdr_t          hdr_q,
   output oob_ctl_t          ctl_q,
   output logic              start,
   output logic [7:0]        reg_rdata
);

   localparam logic [ADDR_W-1:0] A_KIND = CTL_ADDR + ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_TL   = CTL_ADDR + ADDR_W'(2);
   localparam logic [ADDR_W-1:0] A_LEN  = CTL_ADDR + ADDR_W'(3);

   logic wr_ctl, wr_kind, wr_tl, wr_len;

   always_comb begin
      wr_ctl  = bus_wr && (bus_addr == CTL_ADDR);
      wr_kind = bus_wr && !busy && (bus_addr == A_KIND);
      wr_tl   = bus_wr && !busy && (bus_addr == A_TL);
      wr_len  = bus_wr && !busy && (bus_addr == A_LEN);
   end

   // go is honoured only against the enable value held before this write
   assign start = wr_ctl && bus_wdata[CTL_GO] && ctl_q.en && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         hdr_q <= '0;
      end else begin
         if (wr_ctl) begin
            ctl_q.en <= bus_wdata[CTL_EN];
            ctl_q.ie <= bus_wdata[CTL_IE];
            if (bus_wdata[CTL_DONE])  ctl_q.done  <= 1'b0;
            if (bus_wdata[CTL_ERR])   ctl_q.err   <= 1'b0;
            if (bus_wdata[CTL_CHDIS]) ctl_q.chdis <= 1'b0;
         end
         // hardware events win over a same-cycle clear
         if (set_done)  ctl_q.done  <= 1'b1;
         if (set_err)   ctl_q.err   <= 1'b1;
         if (set_chdis) ctl_q.chdis <= 1'b1;
         if (wr_kind) hdr_q.kind   <= bus_wdata;
         if (wr_tl)   hdr_q.taglen <= bus_wdata;
         if (wr_len)  hdr_q.lenlo  <= bus_wdata;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (bus_addr == CTL_ADDR) begin
         reg_rdata[CTL_EN]    = ctl_q.en;
         reg_rdata[CTL_GO]    = 1'b0;
         reg_rdata[CTL_IE]    = ctl_q.ie;
         reg_rdata[CTL_ERR]   = ctl_q.err;
         reg_rdata[CTL_CHDIS] = ctl_q.chdis;
         reg_rdata[CTL_DONE]  = ctl_q.done;
         reg_rdata[CTL_BUSY]  = busy;
      end else if (bus_addr == A_KIND) begin
         reg_rdata = hdr_q.kind;
      end else if (bus_addr == A_TL) begin
         reg_rdata = hdr_q.taglen;
      end else if (bus_addr == A_LEN) begin
         reg_rdata = hdr_q.lenlo;
      end
   end

   // R8: a written 1 clears done unless the engine sets it the same cycle
   assert_w1c_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && bus_wdata[CTL_DONE] && !set_done) |=> !ctl_q.done);

   // R8: a written 0 leaves done as it was
   assert_w1c_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl && !bus_wdata[CTL_DONE] && ctl_q.done) |=> ctl_q.done);

   // R11: header frozen while a message is in flight
   assert_hdr_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && bus_wr) |=> $stable(hdr_q));

endmodule

// File: rtl/oobtx_buffer.sv
module oobtx_buffer #(
   parameter int DEPTH         = 80,
   parameter bit RESET_CONTENT = 1'b1,
   parameter bit READBACK      = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [$clog2(DEPTH)-1:0] wr_addr,
   input  logic [7:0]               wr_data,
   input  logic [$clog2(DEPTH)-1:0] bus_raddr,
   output logic [7:0]               bus_rdata,
   input  logic [$clog2(DEPTH)-1:0] seq_raddr,
   output logic [7:0]               seq_rdata
);

   localparam int            AW  = $clog2(DEPTH);
   localparam logic [AW:0]   LIM = (AW+1)'(DEPTH);

   logic [7:0] mem [DEPTH];
   logic       wr_ok;

   assign wr_ok = wr_en && ({1'b0, wr_addr} < LIM);

   if (RESET_CONTENT) begin : g_rst_mem
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (wr_ok) begin
            mem[wr_addr] <= wr_data;
         end
      end
   end else begin : g_plain_mem
      logic unused_rst;
      assign unused_rst = rst_n;
      always_ff @(posedge clk) begin
         if (wr_ok) mem[wr_addr] <= wr_data;
      end
   end

   assign seq_rdata = ({1'b0, seq_raddr} < LIM) ? mem[seq_raddr] : '0;

   if (READBACK) begin : g_readback
      assign bus_rdata = ({1'b0, bus_raddr} < LIM) ? mem[bus_raddr] : '0;
   end else begin : g_no_readback
      logic [AW-1:0] unused_raddr;
      assign unused_raddr = bus_raddr;
      assign bus_rdata    = '0;
   end

endmodule

// File: rtl/oobtx_seq.sv
module oobtx_seq
   import oobtx_pkg::*;
#(
   parameter int DEPTH = 80
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  oob_hdr_t                 hdr,
   input  logic                     host_chan_off,
   input  logic                     tx_ready,
   input  logic [7:0]               buf_rdata,
   output logic [$clog2(DEPTH)-1:0] buf_raddr,
   output logic                     busy,
   output logic                     tx_valid,
   output logic [7:0]               tx_data,
   output logic                     tx_last,
   output logic                     set_done,
   output logic                     set_err,
   output logic                     set_chdis
);

   localparam int AW    = $clog2(DEPTH);
   localparam int IDX_W = $clog2(DEPTH + HDR_BYTES);
   localparam int CMP_W = LEN_W + 1;

   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] pay_idx;
   logic [LEN_W-1:0] msg_len;
   logic [CMP_W-1:0] last_idx;
   logic             len_bad;
   logic             at_last;
   logic             fire;

   assign msg_len  = {hdr.taglen[3:0], hdr.lenlo};
   assign len_bad  = msg_len > LEN_W'(DEPTH);
   assign last_idx = {1'b0, msg_len} + CMP_W'(HDR_BYTES - 1);
   assign at_last  = (CMP_W'(idx_q) == last_idx);
   assign pay_idx  = idx_q - IDX_W'(HDR_BYTES);
   assign buf_raddr = AW'(pay_idx);

   assign tx_valid = busy;
   assign tx_last  = busy && at_last;
   assign fire     = busy && tx_ready && !host_chan_off;

   always_comb begin
      case (idx_q)
         IDX_W'(0): tx_data = hdr.kind;
         IDX_W'(1): tx_data = hdr.taglen;
         IDX_W'(2): tx_data = hdr.lenlo;
         default:   tx_data = buf_rdata;
      endcase
   end

   assign set_err   = start && len_bad;
   assign set_done  = (start && len_bad) || (fire && at_last);
   assign set_chdis = busy && host_chan_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         idx_q <= '0;
      end else if (busy) begin
         if (host_chan_off) begin
            busy <= 1'b0;
         end else if (fire) begin
            if (at_last) busy  <= 1'b0;
            else         idx_q <= idx_q + IDX_W'(1);
         end
      end else if (start && !len_bad) begin
         busy  <= 1'b1;
         idx_q <= '0;
      end
   end

   // R5: stalled byte holds
   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready && !host_chan_off) |=>
         (tx_valid && $stable(tx_data) && $stable(tx_last)));

   // R4: never walks past the final byte
   assert_idx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (CMP_W'(idx_q) <= last_idx));

   // R9: channel-off abandons the message
   assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && host_chan_off) |=> !tx_valid);

endmodule

// File: rtl/oob_upstream_tx.sv
module oob_upstream_tx
   import oobtx_pkg::*;
#(
   parameter int                BUF_DEPTH    = 80,
   parameter int                ADDR_W       = 8,
   parameter logic [ADDR_W-1:0] CTL_ADDR     = 8'h80,
   parameter bit                RESET_BUF    = 1'b1,
   parameter bit                BUF_READBACK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              host_chan_off,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [7:0]        tx_data,
   output logic              tx_last,
   output logic              irq
);

   localparam int                BUF_AW  = $clog2(BUF_DEPTH);
   localparam logic [ADDR_W-1:0] BUF_END = ADDR_W'(BUF_DEPTH);

   // elaboration-time parameter checks
   if (BUF_DEPTH < 2 || BUF_DEPTH > 4095) begin : g_bad_depth
      $error("BUF_DEPTH must lie in 2..4095");
   end
   if (BUF_DEPTH > int'(CTL_ADDR)) begin : g_bad_overlap
      $error("staging buffer overlaps the control registers");
   end
   if (int'(CTL_ADDR) + 3 >= (1 << ADDR_W)) begin : g_bad_addr
      $error("header registers fall outside the address space");
   end

   oob_hdr_t          hdr_q;
   oob_ctl_t          ctl_q;
   logic              start, busy;
   logic              set_done, set_err, set_chdis;
   logic [7:0]        reg_rdata, buf_bus_rdata, buf_seq_rdata;
   logic [BUF_AW-1:0] seq_raddr;
   logic              buf_hit, buf_wr;

   assign buf_hit = bus_addr < BUF_END;
   assign buf_wr  = bus_wr && buf_hit && !busy;

   oobtx_regs #(
      .ADDR_W   (ADDR_W),
      .CTL_ADDR (CTL_ADDR)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .busy      (busy),
      .set_done  (set_done),
      .set_err   (set_err),
      .set_chdis (set_chdis),
      .hdr_q     (hdr_q),
      .ctl_q     (ctl_q),
      .start     (start),
      .reg_rdata (reg_rdata)
   );

   oobtx_buffer #(
      .DEPTH         (BUF_DEPTH),
      .RESET_CONTENT (RESET_BUF),
      .READBACK      (BUF_READBACK)
   ) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (buf_wr),
      .wr_addr   (BUF_AW'(bus_addr)),
      .wr_data   (bus_wdata),
      .bus_raddr (BUF_AW'(bus_addr)),
      .bus_rdata (buf_bus_rdata),
      .seq_raddr (seq_raddr),
      .seq_rdata (buf_seq_rdata)
   );

   oobtx_seq #(
      .DEPTH (BUF_DEPTH)
   ) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .hdr           (hdr_q),
      .host_chan_off (host_chan_off),
      .tx_ready      (tx_ready),
      .buf_rdata     (buf_seq_rdata),
      .buf_raddr     (seq_raddr),
      .busy          (busy),
      .tx_valid      (tx_valid),
      .tx_data       (tx_data),
      .tx_last       (tx_last),
      .set_done      (set_done),
      .set_err       (set_err),
      .set_chdis     (set_chdis)
   );

   assign bus_rdata = buf_hit ? buf_bus_rdata : reg_rdata;
   assign irq       = ctl_q.ie && (ctl_q.done || ctl_q.chdis);

   // R6: final handshake leads to done with the stream closed
   assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && tx_last && !host_chan_off) |=> (ctl_q.done && !tx_valid));

   // R7: a refused length never offers a byte
   assert_err_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_q.err) |-> !tx_valid);

   // R10: interrupt holds until the control register is written
   assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(bus_wr && bus_addr == CTL_ADDR)) |=> irq);

endmodule

// File: tb/tb_oob_upstream_tx.sv
module tb_oob_upstream_tx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       host_chan_off = 1'b0;
   logic       tx_valid, tx_ready = 1'b0, tx_last, irq;
   logic [7:0] tx_data;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   oob_upstream_tx dut (
      .clk (clk), .rst_n (rst_n),
      .bus_wr (bus_wr), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata), .host_chan_off (host_chan_off),
      .tx_valid (tx_valid), .tx_ready (tx_ready), .tx_data (tx_data),
      .tx_last (tx_last), .irq (irq)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000) begin
         n_bad++;
         $display("FAIL watchdog: run hung, actual=%0d expected<150000", cycles);
         $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
         $finish;
      end
   end

   // {tag[3:0], len[11:0], seed[7:0], ready pattern[7:0]}
   localparam logic [31:0] VEC [6] = '{
      {4'h1, 12'd0,  8'h10, 8'hFF},
      {4'h2, 12'd1,  8'h20, 8'h55},
      {4'h3, 12'd5,  8'hA0, 8'hFF},
      {4'h4, 12'd16, 8'h33, 8'h93},
      {4'h5, 12'd80, 8'h01, 8'hFF},
      {4'hF, 12'd80, 8'h80, 8'h11}
   };

   logic [7:0] got [0:95];
   int         got_n, last_pos;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk); bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic collect(input logic [7:0] pat);
      int  cyc = 0;
      bit  fin = 1'b0;
      got_n = 0; last_pos = -1;
      while (!fin && cyc < 2000) begin
         @(negedge clk);
         tx_ready = pat[3'(cyc)];
         #1;
         if (tx_valid && tx_ready && got_n < 96) begin
            got[got_n] = tx_data;
            if (tx_last) begin last_pos = got_n; fin = 1'b1; end
            got_n++;
         end
         cyc++;
      end
      @(negedge clk); tx_ready = 1'b0;
   endtask

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      #1;
      chk("R1 tx_valid", int'(tx_valid), 0);
      chk("R1 irq", int'(irq), 0);
      rd(8'h80, d); chk("R1 control", d, 0);
      rd(8'h81, d); chk("R1 kind", d, 0);
      rd(8'h82, d); chk("R1 tag/len-high", d, 0);
      rd(8'h83, d); chk("R1 len-low", d, 0);
      rd(8'h10, d); chk("R1 buffer", d, 0);

      // R3: go without prior enable sends nothing
      wr(8'h80, 8'h40); #1; chk("R3 go with enable off", int'(tx_valid), 0);
      rd(8'h80, d); chk("R3 control after lone go", d, 8'h00);
      wr(8'h80, 8'hC0); #1; chk("R3 go with enable in same write", int'(tx_valid), 0);
      rd(8'h80, d); chk("R2 go reads 0", d, 8'h80);

      // table of messages: R4 R5 R6 R8 R10 R12 R2
      for (int v = 0; v < 6; v++) begin
         logic [3:0]  tag;
         logic [11:0] len;
         logic [7:0]  seed, pat;
         int          mism;
         {tag, len, seed, pat} = VEC[v];
         wr(8'h81, 8'h07);
         wr(8'h82, {tag, len[11:8]});
         wr(8'h83, len[7:0]);
         for (int i = 0; i < int'(len); i++) wr(8'(i), seed + 8'(i * 3));
         wr(8'h80, 8'hA0);
         wr(8'h80, 8'hE0);
         collect(pat);
         mism = 0;
         for (int i = 0; i < got_n; i++) begin
            logic [7:0] e;
            if (i == 0)      e = 8'h07;
            else if (i == 1) e = {tag, len[11:8]};
            else if (i == 2) e = len[7:0];
            else             e = seed + 8'((i - 3) * 3);
            if (got[i] != e) mism++;
         end
         chk("R4/R5 byte mismatches", mism, 0);
         chk("R4 byte count", got_n, int'(len) + 3);
         chk("R4 last position", last_pos, int'(len) + 2);
         if (len == 0) chk("R12 header-only last", last_pos, 2);
         rd(8'h80, d); chk("R6 status after send", d, 8'hA2);
         chk("R10 irq on done", int'(irq), 1);
         wr(8'h80, 8'h22);
         rd(8'h80, d); chk("R8 done cleared, enable dropped", d, 8'h20);
         chk("R10 irq after clear", int'(irq), 0);
      end
      rd(8'h05, d); chk("R2 buffer readback", d, 8'h80 + 8'd15);

      // R7: length 81 refused
      wr(8'h82, 8'h00); wr(8'h83, 8'h51);
      wr(8'h80, 8'hA0); wr(8'h80, 8'hE0); #1;
      chk("R7 no byte on overlong", int'(tx_valid), 0);
      rd(8'h80, d); chk("R7 error and done", d, 8'hAA);
      chk("R10 irq on refused", int'(irq), 1);
      wr(8'h80, 8'hA2);
      rd(8'h80, d); chk("R8 zero leaves error", d, 8'hA8);
      chk("R10 error alone no irq", int'(irq), 0);
      wr(8'h80, 8'hA8);
      // R7: high nibble counts
      wr(8'h82, 8'h01); wr(8'h83, 8'h00);
      wr(8'h80, 8'hE0); #1;
      chk("R7 no byte on high nibble", int'(tx_valid), 0);
      rd(8'h80, d); chk("R7 high nibble refused", d, 8'hAA);
      wr(8'h80, 8'hAA);

      // R11: writes during a transfer are ignored
      wr(8'h81, 8'h07); wr(8'h82, 8'h20); wr(8'h83, 8'h04);
      for (int i = 0; i < 4; i++) wr(8'(i), 8'h40 + 8'(i));
      wr(8'h80, 8'hA0); wr(8'h80, 8'hE0);
      rd(8'h80, d); chk("R6 busy while sending", d, 8'hA1);
      wr(8'h80, 8'hE0);
      wr(8'h83, 8'h09);
      wr(8'h00, 8'hEE);
      rd(8'h83, d); chk("R11 header locked", d, 8'h04);
      collect(8'hFF);
      chk("R11 count after second go", got_n, 7);
      chk("R11 payload byte 0", int'(got[3]), 8'h40);
      chk("R11 last payload", int'(got[6]), 8'h43);
      wr(8'h80, 8'h22);

      // R10: interrupt gated by enable bit
      wr(8'h83, 8'h01);
      wr(8'h80, 8'h80); wr(8'h80, 8'hC0);
      collect(8'hFF);
      chk("R10 irq masked", int'(irq), 0);
      wr(8'h80, 8'hA0); #1;
      chk("R10 irq unmasked", int'(irq), 1);
      wr(8'h80, 8'h22);

      // R9: host disables channel mid-message
      wr(8'h83, 8'h0A);
      wr(8'h80, 8'hA0); wr(8'h80, 8'hE0);
      @(negedge clk); @(negedge clk);
      host_chan_off = 1'b1;
      @(negedge clk); host_chan_off = 1'b0; #1;
      chk("R9 valid dropped", int'(tx_valid), 0);
      rd(8'h80, d); chk("R9 channel-disabled, no done", d, 8'hA4);
      chk("R10 irq on channel-disabled", int'(irq), 1);
      wr(8'h80, 8'hA4);
      rd(8'h80, d); chk("R8 channel-disabled cleared", d, 8'hA0);
      chk("R10 irq cleared", int'(irq), 0);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule